// File: doc/BRIEF.md
# Multicart CHR Bank Address Generator

This block turns a 13-bit pattern-table address from the picture unit into a byte address inside program ROM. It is needed because the carts it serves carry no separate character memory. The pattern space is split into eight 1 KB slots. Each slot takes its bank number from a slot register, a mode-dependent mask and an outer block base.

The six slot registers are loaded through the command/data pair on the program side. A data write carries a 3-bit select taken from the command value. Two slot registers each cover a 2 KB pair of slots. The other four each cover a single 1 KB slot. The inversion bit of the command value exchanges the lower and upper 4 KB halves.

Three inputs come from outside the block, since their own registers live elsewhere:
- the low nibble of the outer program page;
- the three outer character bits;
- the character mode byte.

The address lookup itself is purely combinational. A change on any input shows on the output in the same cycle.

Top module: `chr_bank_map`

## Requirements
- R1: After reset all six slot registers read zero. With zero outer inputs, mode byte zero and inversion off, the odd slots 1 and 3 map to bank 1 and every other slot maps to bank 0.
- R2: A data write (`bank_wr` high at a clock edge) stores `bank_wdata` into one register, chosen by `cmd_sel`. Select 0 loads the pair register for slots 0/1, select 1 loads the pair register for slots 2/3, and selects 2, 3, 4 and 5 load the registers for slots 4, 5, 6 and 7.
- R3: The even slot of a pair uses its pair register with bit 0 cleared. The odd slot uses the same register with bit 0 set.
- R4: Slots 4 to 7 each use their single register unchanged, apart from masking.
- R5: With `cmd_inv` high, slot index s uses the register of slot s XOR 4.
- R6: The mode is `chr_mode[2:0]`. The mask is 0xFF shifted right by 0, 1, 2, 0, 3, 4, 5, 0 for modes 0 to 7. The low bank byte is (raw AND mask) OR (`chr_mode` AND NOT mask).
- R7: The bank number is 15 bits wide. Bits 14..11 hold `outer_lo`, bits 10..8 hold `chr_outer`, and bits 7..0 are the byte from R6.
- R8: `rom_addr` equals bank times 1024 plus `ppu_addr[9:0]`. The slot index is `ppu_addr[12:10]`.
- R9: A data write with select 6 or 7, or a clock edge with `bank_wr` low, leaves every slot mapping unchanged.
- R10: A write to the pattern range (`ppu_wr` high) has no effect. `rom_rd` stays low and no slot mapping changes. A read (`ppu_rd` high, `ppu_wr` low) drives `rom_rd` high.
- R11: The lookup is combinational. A change of `ppu_addr`, `cmd_inv` or the outer inputs shows on `rom_addr` without a clock edge. A register write shows after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears slot registers |
| bank_wr | input | 1 | Data write strobe of the command/data pair |
| cmd_sel | input | 3 | Register select from the command value |
| cmd_inv | input | 1 | Half-inversion bit from the command value |
| bank_wdata | input | 8 | Data written to the selected slot register |
| outer_lo | input | OUTER_W | Low nibble of the outer program page |
| chr_outer | input | 3 | Outer character block bits |
| chr_mode | input | 8 | Character mode byte: mode in bits 2..0, fixed bank bits above the mask |
| ppu_addr | input | PPU_AW | Pattern-table address |
| ppu_rd | input | 1 | Pattern read request |
| ppu_wr | input | 1 | Pattern write request (ignored) |
| rom_addr | output | ROM_AW | Byte address into program ROM |
| rom_rd | output | 1 | ROM read enable |

## Verification
A slot register loaded with the wrong value or into the wrong index does not stay hidden. It shows as a wrong bank field on `rom_addr` the first time its slot is addressed, one edge after the write. A faulty select map or a missing bit-0 force shows at once on the affected slot, and a broken inversion shows on the partner half. Mask errors appear only in the modes that use a given shift, which is why every mode is swept. Corruption of the registers by ignored writes is exposed by re-reading all eight slots afterwards.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
    localparam int CHR_DW   = 8;
    localparam int SEL_W    = 3;
    localparam int NUM_REGS = 6;
    localparam int MODE_W   = 3;

    typedef logic [CHR_DW-1:0] chr_byte_t;

    typedef struct packed {
        logic [NUM_REGS-1:0][CHR_DW-1:0] bank;
    } chr_regs_t;

    function automatic int unsigned mask_shift(input logic [MODE_W-1:0] mode);
        case (mode)
            3'd1:    return 1;
            3'd2:    return 2;
            3'd4:    return 3;
            3'd5:    return 4;
            3'd6:    return 5;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
    import chr_map_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     sel,
    input  chr_byte_t            wdata,
    output chr_regs_t            regs
);
    chr_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && sel == SEL_W'(i)) begin
                regs_d.bank[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;
endmodule

// File: rtl/chr_mask_gen.sv
module chr_mask_gen
    import chr_map_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output chr_byte_t         mask
);
    always_comb begin
        mask = chr_byte_t'({CHR_DW{1'b1}}) >> mask_shift(mode);
    end
endmodule

// File: rtl/chr_slot_sel.sv
module chr_slot_sel
    import chr_map_pkg::*;
(
    input  logic [2:0] slot,
    input  logic       invert,
    input  chr_regs_t  regs,
    output chr_byte_t  raw
);
    logic [2:0] eff;
    chr_byte_t  pair;

    always_comb begin
        eff  = slot ^ {invert, 2'b00};
        pair = regs.bank[{2'b00, eff[1]}];
        if (eff[2]) begin
            raw = regs.bank[{1'b0, eff[1:0]} + 3'd2];
        end else begin
            raw = {pair[CHR_DW-1:1], eff[0]};
        end
    end
endmodule

// File: rtl/chr_bank_map.sv
module chr_bank_map
    import chr_map_pkg::*;
#(
    parameter int OUTER_W = 4,
    parameter int SLOT_AW = 10,
    parameter int PPU_AW  = 13,
    localparam int CO_W   = 3,
    localparam int BANK_W = OUTER_W + CO_W + CHR_DW,
    localparam int ROM_AW = BANK_W + SLOT_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bank_wr,
    input  logic [SEL_W-1:0]   cmd_sel,
    input  logic               cmd_inv,
    input  logic [7:0]         bank_wdata,
    input  logic [OUTER_W-1:0] outer_lo,
    input  logic [CO_W-1:0]    chr_outer,
    input  logic [7:0]         chr_mode,
    input  logic [PPU_AW-1:0]  ppu_addr,
    input  logic               ppu_rd,
    input  logic               ppu_wr,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               rom_rd
);
    chr_regs_t regs;
    chr_byte_t mask;
    chr_byte_t raw;
    chr_byte_t low_bank;

    chr_bank_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bank_wr),
        .sel   (cmd_sel),
        .wdata (bank_wdata),
        .regs  (regs)
    );

    chr_mask_gen u_mask (
        .mode (chr_mode[MODE_W-1:0]),
        .mask (mask)
    );

    chr_slot_sel u_sel (
        .slot   (ppu_addr[PPU_AW-1 -: 3]),
        .invert (cmd_inv),
        .regs   (regs),
        .raw    (raw)
    );

    always_comb begin
        low_bank = (raw & mask) | (chr_mode & ~mask);
        rom_addr = {outer_lo, chr_outer, low_bank, ppu_addr[SLOT_AW-1:0]};
        rom_rd   = ppu_rd & ~ppu_wr;
    end
endmodule

// File: rtl/chr_bank_map_chk.sv
module chr_bank_map_chk #(
    parameter int OUTER_W = 4,
    parameter int SLOT_AW = 10,
    parameter int PPU_AW  = 13,
    localparam int ROM_AW = OUTER_W + 3 + 8 + SLOT_AW
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bank_wr,
    input logic [2:0]         cmd_sel,
    input logic               cmd_inv,
    input logic [OUTER_W-1:0] outer_lo,
    input logic [2:0]         chr_outer,
    input logic [7:0]         chr_mode,
    input logic [PPU_AW-1:0]  ppu_addr,
    input logic               ppu_wr,
    input logic [ROM_AW-1:0]  rom_addr,
    input logic               rom_rd
);
    logic [2:0] slot;
    logic       no_store;
    assign slot     = ppu_addr[PPU_AW-1 -: 3];
    assign no_store = !bank_wr || (cmd_sel > 3'd5);

    assert_outer_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[ROM_AW-1 -: OUTER_W] == outer_lo &&
        rom_addr[SLOT_AW+8 +: 3] == chr_outer);

    assert_mode6_fixed_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_mode[2:0] == 3'd6) |-> rom_addr[SLOT_AW+3 +: 5] == chr_mode[7:3]);

    assert_pair_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_inv && slot == 3'd1) |-> rom_addr[SLOT_AW]);

    assert_pair_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_inv && slot == 3'd0) |-> !rom_addr[SLOT_AW]);

    assert_no_rom_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ppu_wr |-> !rom_rd);

    assert_ignored_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        no_store |=> (!($stable(ppu_addr) && $stable(cmd_inv) && $stable(outer_lo) &&
                        $stable(chr_outer) && $stable(chr_mode)) || $stable(rom_addr)));
endmodule

bind chr_bank_map chr_bank_map_chk #(
    .OUTER_W (OUTER_W),
    .SLOT_AW (SLOT_AW),
    .PPU_AW  (PPU_AW)
) u_chk (.*);

// File: tb/chr_bank_map_tb.sv
module chr_bank_map_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_wr = 1'b0;
    logic [2:0]  cmd_sel = '0;
    logic        cmd_inv = 1'b0;
    logic [7:0]  bank_wdata = '0;
    logic [3:0]  outer_lo = '0;
    logic [2:0]  chr_outer = '0;
    logic [7:0]  chr_mode = '0;
    logic [12:0] ppu_addr = '0;
    logic        ppu_rd = 1'b0;
    logic        ppu_wr = 1'b0;
    logic [24:0] rom_addr;
    logic        rom_rd;

    int errors = 0;
    int checks = 0;
    logic [7:0] m [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    chr_bank_map u_dut (
        .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .cmd_sel(cmd_sel),
        .cmd_inv(cmd_inv), .bank_wdata(bank_wdata), .outer_lo(outer_lo),
        .chr_outer(chr_outer), .chr_mode(chr_mode), .ppu_addr(ppu_addr),
        .ppu_rd(ppu_rd), .ppu_wr(ppu_wr), .rom_addr(rom_addr), .rom_rd(rom_rd)
    );

    function automatic logic [7:0] exp_mask(input logic [2:0] md);
        case (md)
            3'd1: return 8'h7F;
            3'd2: return 8'h3F;
            3'd4: return 8'h1F;
            3'd5: return 8'h0F;
            3'd6: return 8'h07;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [24:0] exp_addr(input logic [12:0] a);
        logic [2:0] s;
        logic [7:0] r, mk;
        s = a[12:10] ^ {cmd_inv, 2'b00};
        case (s)
            3'd0: r = {m[0][7:1], 1'b0};
            3'd1: r = {m[0][7:1], 1'b1};
            3'd2: r = {m[1][7:1], 1'b0};
            3'd3: r = {m[1][7:1], 1'b1};
            default: r = m[s - 3'd2];
        endcase
        mk = exp_mask(chr_mode[2:0]);
        return ({10'd0, outer_lo, 11'd0} | {14'd0, chr_outer, 8'd0}
                | {17'd0, (r & mk) | (chr_mode & ~mk)}) * 25'd1024 + {15'd0, a[9:0]};
    endfunction

    task automatic chk(input string tag, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic store(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        cmd_sel = sel; bank_wdata = d; bank_wr = 1'b1;
        @(negedge clk);
        bank_wr = 1'b0;
        if (sel < 3'd6) m[sel] = d;
    endtask

    task automatic sweep(input string tag);
        for (int s = 0; s < 8; s++) begin
            ppu_addr = {s[2:0], 10'h15A};
            #1;
            chk(tag, rom_addr, exp_addr(ppu_addr));
        end
    endtask

    task automatic t_reset;
        ppu_addr = 13'h0412; #1;
        chk("R1 slot1 after reset", rom_addr, 25'h412);
        sweep("R1 reset sweep");
    endtask

    task automatic t_pairs;
        store(3'd0, 8'h24);
        store(3'd1, 8'h31);
        ppu_addr = 13'h0000; #1; chk("R2/R3 slot0", rom_addr, 25'h24 * 1024);
        ppu_addr = 13'h0400; #1; chk("R3 slot1", rom_addr, 25'h25 * 1024);
        ppu_addr = 13'h0800; #1; chk("R3 slot2", rom_addr, 25'h30 * 1024);
        ppu_addr = 13'h0C07; #1; chk("R3 slot3", rom_addr, 25'h31 * 1024 + 7);
    endtask

    task automatic t_singles;
        store(3'd2, 8'h40); store(3'd3, 8'h51);
        store(3'd4, 8'h62); store(3'd5, 8'h73);
        ppu_addr = 13'h1C00; #1; chk("R4 slot7", rom_addr, 25'h73 * 1024);
        sweep("R2/R4 sweep");
    endtask

    task automatic t_invert;
        cmd_inv = 1'b1;
        ppu_addr = 13'h0000; #1; chk("R5 slot0 inverted", rom_addr, 25'h40 * 1024);
        ppu_addr = 13'h1400; #1; chk("R5 slot5 inverted", rom_addr, 25'h25 * 1024);
        sweep("R5 sweep");
        cmd_inv = 1'b0;
    endtask

    task automatic t_modes;
        for (int md = 0; md < 8; md++) begin
            chr_mode = 8'hA8 | 8'(md);
            sweep("R6 mode sweep");
        end
        chr_mode = 8'hAE;
        ppu_addr = 13'h1400; #1; chk("R6 mode6 slot5", rom_addr, 25'hA9 * 1024);
        chr_mode = 8'h00;
    endtask

    task automatic t_base;
        outer_lo = 4'hB; chr_outer = 3'd5;
        ppu_addr = 13'h1803; #1;
        chk("R7/R8 base", rom_addr, ((25'hB << 11) | (25'd5 << 8) | 25'h62) * 1024 + 3);
        sweep("R7 sweep");
        outer_lo = 4'h0; chr_outer = 3'd0;
    endtask

    task automatic t_ignored;
        store(3'd6, 8'hFF);
        store(3'd7, 8'hEE);
        @(negedge clk);
        cmd_sel = 3'd0; bank_wdata = 8'h99;
        @(negedge clk);
        sweep("R9 ignored writes");
    endtask

    task automatic t_ppu_write;
        ppu_addr = 13'h0400; ppu_rd = 1'b1; ppu_wr = 1'b0; #1;
        chk("R10 read enable", {24'd0, rom_rd}, 25'd1);
        ppu_wr = 1'b1;
        @(negedge clk); #1;
        chk("R10 no rom on write", {24'd0, rom_rd}, 25'd0);
        @(negedge clk);
        ppu_wr = 1'b0; ppu_rd = 1'b0;
        sweep("R10 map after write");
    endtask

    task automatic t_comb;
        ppu_addr = 13'h0000; #1;
        ppu_addr = 13'h1000; outer_lo = 4'h3; #1;
        chk("R11 comb update", rom_addr, exp_addr(13'h1000));
        outer_lo = 4'h0;
    endtask

    initial begin
        for (int i = 0; i < 6; i++) m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pairs();
        t_singles();
        t_invert();
        t_modes();
        t_base();
        t_ignored();
        t_ppu_write();
        t_comb();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule